// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Front-End

This block is the write half of a two-wire serial EEPROM slave for a 4 KiB (32-kbit) byte array. A fast system clock oversamples the serial clock and data lines. The block finds START and STOP conditions and shifts in bytes on rising serial-clock edges. It acknowledges by pulling the data line low through an open-drain enable. A transaction that the block accepts carries its own device address with the direction bit clear, then two address bytes, then any number of data bytes.

For every data byte the block accepts, it gives a page buffer a one-cycle strobe with the byte and its 12-bit address. A STOP after at least one accepted data byte raises a commit request. That request starts a stand-in write cycle, whose length in system clocks comes from a programmable counter. While this cycle runs, the block refuses to acknowledge anything. A master can therefore poll with repeated address bytes until it gets an acknowledge.

The block samples a write-protect input once per transaction, on the last serial-clock fall before the first data byte. If that sample is high, the block refuses the first data byte and drops the whole write.

Top module: `eepromWriteSlave`

## Requirements
- R1: After a START, the byte {DEV_ADDR, 0} (seven address bits first, direction bit last, 0 = write) is acknowledged when not busy. Any other value, including the same address with direction bit 1, is not acknowledged, and every following byte up to the next START or STOP is ignored (no acknowledge, no byte strobe).
- R2: The two bytes after the device address are acknowledged. They form the 12-bit start address {first[3:0], second}. The upper four bits of the first byte are ignored.
- R3: Each accepted data byte is acknowledged and produces a one-cycle `byteValid` pulse with that byte on `byteData` and its address on `byteAddr`.
- R4: After each accepted data byte, the address advances by one inside a 32-byte page. Bits [4:0] wrap from 31 to 0, and bits [11:5] never change.
- R5: A STOP after at least one accepted data byte gives a one-cycle `commitReq` pulse. `busy` is then high for exactly `cycleLimit` clocks, or one clock if `cycleLimit` is 0.
- R6: While `busy` is high, no byte is acknowledged, including a correct device address. The same device address is acknowledged once `busy` has dropped.
- R7: `wpIn` is sampled on the serial-clock fall that ends the acknowledge of the second address byte. If the sample is 1, the first data byte is not acknowledged, no byte strobe is given, and the following STOP gives no commit and no busy period.
- R8: `wpIn` has no effect at any other time. A high level that goes away before the sampling fall, or that arrives after it, still lets the write complete and commit.
- R9: A STOP or START that arrives after two or more bits of a byte have been clocked aborts the transaction: no commit and no busy period.
- R10: A STOP after the address phase with no accepted data byte gives no commit and no busy period.
- R11: `sdaOe` is 0 after reset and during all data bits. It rises after the serial-clock fall that ends the eighth bit of an acknowledged byte, and it falls after the next fall. `busy`, `byteValid` and `commitReq` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | 1 pulls the data line low (acknowledge) |
| wpIn | input | 1 | Write-protect level |
| cycleLimit | input | CNT_W | Length of the internal write cycle in clocks |
| busy | output | 1 | Internal write cycle in progress |
| byteValid | output | 1 | One-cycle strobe for an accepted data byte |
| byteData | output | 8 | Accepted data byte |
| byteAddr | output | ADDR_W | Address of the accepted data byte |
| commitReq | output | 1 | One-cycle request to commit the page buffer |

## Verification
The bench writes four bytes that start two below a page end. A design that carries into bit 5, or that keeps the upper nibble of the first address byte, reports the wrong addresses. It polls right after a commit: acknowledging the device address while busy, or never acknowledging it afterwards, is caught, and so is a busy period of the wrong length. Write-protect is driven high across the whole transaction, then dropped just before its sampling edge, then raised just after it. This catches a design that samples the level at the wrong moment or keeps following it. Finally, a STOP or START in the middle of a byte, and a STOP with no data, must leave `commitReq` and `busy` low. Stray drives of `sdaOe` during data bits are counted.

// File: rtl/ewsPkg.sv
package ewsPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_DATA,
    S_SKIP
  } ewsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ackGive;   // acknowledge the byte just received
    logic ldHi;      // load upper address nibble
    logic ldLo;      // load full start address
    logic emit;      // hand data byte to the page buffer
    logic wpWindow;  // next ack-ending fall samples write-protect
    logic commit;    // start the internal write cycle
  } ewsCtl_s;

endpackage

// File: rtl/ewsLineSync.sv
module ewsLineSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclSh, sdaSh;
  logic sclQ, sdaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSh <= {sclSh[MSB-1:0], sclIn};
      sdaSh <= {sdaSh[MSB-1:0], sdaIn};
      sclQ  <= sclSh[MSB];
      sdaQ  <= sdaSh[MSB];
    end
  end

  assign sdaLvl   = sdaSh[MSB];
  assign sclRise  = sclSh[MSB] & ~sclQ;
  assign sclFall  = ~sclSh[MSB] & sclQ;
  // data edges while the clock stays high
  assign startDet = sclSh[MSB] & sclQ & sdaQ & ~sdaSh[MSB];
  assign stopDet  = sclSh[MSB] & sclQ & ~sdaQ & sdaSh[MSB];

endmodule

// File: rtl/ewsDatapath.sv
module ewsDatapath import ewsPkg::*; #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              wpIn,
  input  logic [CNT_W-1:0]  cycleLimit,
  input  ewsCtl_s           ctl,
  output logic [7:0]        rxByte,
  output logic              byteDone,
  output logic [3:0]        bitCnt,
  output logic              wpLat,
  output logic              busy,
  output logic              sdaOe,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic [ADDR_W-1:0] byteAddr,
  output logic              commitReq
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] BIT_FULL = 4'd8;   // eight bits in, ack pending
  localparam logic [3:0] ACK_LOW  = 4'd9;   // ack slot, clock low
  localparam logic [3:0] ACK_HIGH = 4'd10;  // ack slot, clock high

  logic              ackPend;
  logic [1:0]        wpSh;
  logic [HI_W-1:0]   hiNib;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  busyCnt;
  logic              boundary;

  assign boundary = startDet | stopDet;

  // bit counter, shifter and acknowledge drive
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
      ackPend  <= 1'b0;
      sdaOe    <= 1'b0;
      wpLat    <= 1'b0;
      wpSh     <= '0;
    end else begin
      wpSh     <= {wpSh[0], wpIn};
      byteDone <= !boundary && sclRise && (bitCnt == 4'd7);
      if (ctl.ackGive) ackPend <= 1'b1;
      if (boundary) begin
        bitCnt  <= '0;
        sdaOe   <= 1'b0;
        ackPend <= 1'b0;
      end else if (sclRise) begin
        if (bitCnt < BIT_FULL) begin
          rxByte <= {rxByte[6:0], sdaLvl};
          bitCnt <= bitCnt + 4'd1;
        end else if (bitCnt == ACK_LOW) begin
          bitCnt <= ACK_HIGH;
        end
      end else if (sclFall) begin
        if (bitCnt == BIT_FULL) begin
          bitCnt  <= ACK_LOW;
          sdaOe   <= ackPend;
          ackPend <= 1'b0;
        end else if (bitCnt == ACK_HIGH) begin
          bitCnt <= '0;
          sdaOe  <= 1'b0;
          if (ctl.wpWindow) wpLat <= wpSh[1];
        end
      end
    end
  end

  // address register with in-page increment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib     <= '0;
      curAddr   <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteAddr  <= '0;
    end else begin
      byteValid <= ctl.emit;
      if (ctl.ldHi) hiNib <= rxByte[HI_W-1:0];
      if (ctl.ldLo) curAddr <= {hiNib, rxByte};
      if (ctl.emit) begin
        byteData <= rxByte;
        byteAddr <= curAddr;
        curAddr  <= {curAddr[ADDR_W-1:PAGE_W], curAddr[PAGE_W-1:0] + 1'b1};
      end
    end
  end

  // stand-in write cycle timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt   <= '0;
      commitReq <= 1'b0;
    end else begin
      commitReq <= ctl.commit;
      if (ctl.commit) busyCnt <= (cycleLimit == '0) ? CNT_W'(1) : cycleLimit;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (bitCnt == ACK_LOW || bitCnt == ACK_HIGH)); // R11
  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !$rose(sdaOe)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R3
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |=> curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])); // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |=> !commitReq); // R5
  AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && bitCnt >= 4'd2) |=> !commitReq); // R9

endmodule

// File: rtl/ewsControl.sv
module ewsControl import ewsPkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic       wpLat,
  input  logic       busy,
  output ewsCtl_s    ctl
);
  ewsState_e state, stateNxt;
  logic      gotData, gotDataNxt;
  logic      cleanEdge;

  // at most the setup bit of a STOP/START has been clocked
  assign cleanEdge = (bitCnt <= 4'd1);

  always_comb begin
    ctl        = '0;
    stateNxt   = state;
    gotDataNxt = gotData;
    ctl.wpWindow = (state == S_DATA) && !gotData;
    if (startDet) begin
      stateNxt   = S_DEV;
      gotDataNxt = 1'b0;
    end else if (stopDet) begin
      ctl.commit = (state == S_DATA) && gotData && cleanEdge;
      stateNxt   = S_IDLE;
      gotDataNxt = 1'b0;
    end else if (byteDone) begin
      unique case (state)
        S_DEV: begin
          if (rxByte[7:1] == DEV_ADDR && !rxByte[0] && !busy) begin
            ctl.ackGive = 1'b1;
            stateNxt    = S_AHI;
          end else begin
            stateNxt = S_SKIP;
          end
        end
        S_AHI: begin
          ctl.ackGive = 1'b1;
          ctl.ldHi    = 1'b1;
          stateNxt    = S_ALO;
        end
        S_ALO: begin
          ctl.ackGive = 1'b1;
          ctl.ldLo    = 1'b1;
          stateNxt    = S_DATA;
        end
        S_DATA: begin
          if (!gotData && wpLat) begin
            stateNxt = S_SKIP;
          end else begin
            ctl.ackGive = 1'b1;
            ctl.emit    = 1'b1;
            gotDataNxt  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gotData <= 1'b0;
    end else begin
      state   <= stateNxt;
      gotData <= gotDataNxt;
    end
  end

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> busy); // R5
  AST_NO_DEV_ACK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && busy) |-> !ctl.ackGive || state != S_DEV); // R6

endmodule

// File: rtl/eepromWriteSlave.sv
module eepromWriteSlave import ewsPkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 12,
  parameter int         PAGE_W      = 5,
  parameter int         CNT_W       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              wpIn,
  input  logic [CNT_W-1:0]  cycleLimit,
  output logic              busy,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic [ADDR_W-1:0] byteAddr,
  output logic              commitReq
);
  logic       sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic       byteDone, wpLat;
  logic [3:0] bitCnt;
  ewsCtl_s    ctl;

  ewsLineSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  ewsControl #(.DEV_ADDR(DEV_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(rxByte), .bitCnt(bitCnt),
    .wpLat(wpLat), .busy(busy), .ctl(ctl)
  );

  ewsDatapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .wpIn(wpIn), .cycleLimit(cycleLimit), .ctl(ctl),
    .rxByte(rxByte), .byteDone(byteDone), .bitCnt(bitCnt), .wpLat(wpLat),
    .busy(busy), .sdaOe(sdaOe), .byteValid(byteValid),
    .byteData(byteData), .byteAddr(byteAddr), .commitReq(commitReq)
  );

endmodule

// File: tb/eepromWriteSlave_test.sv
`timescale 1ns/1ps
module eepromWriteSlave_test;
  localparam int Q = 8;          // clocks per quarter serial period
  localparam int LIMIT = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic sdaLine;
  logic [15:0] cycleLimit = 16'(LIMIT);
  logic sdaOe, busy, byteValid, commitReq;
  logic [7:0] byteData;
  logic [11:0] byteAddr;

  int checks = 0, errors = 0;
  int validCnt = 0, commitCnt = 0, busyRun = 0, oeBad = 0;
  logic [7:0]  logData [0:15];
  logic [11:0] logAddr [0:15];

  assign sdaLine = sdaM & ~sdaOe;
  always #5 clk = ~clk;

  eepromWriteSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .wpIn(wp), .cycleLimit(cycleLimit), .busy(busy), .byteValid(byteValid),
    .byteData(byteData), .byteAddr(byteAddr), .commitReq(commitReq)
  );

  always @(negedge clk) begin
    if (byteValid) begin
      logData[validCnt % 16] = byteData;
      logAddr[validCnt % 16] = byteAddr;
      validCnt++;
    end
    if (commitReq) begin commitCnt++; busyRun = 0; end
    if (busy) busyRun++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 'h%0h expected 'h%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ(); scl = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(); scl = 1'b1; waitQ();
      if (sdaOe) oeBad++;
      waitQ(); scl = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ();
    ack = sdaOe;
    waitQ(); scl = 1'b0; waitQ();
    if (sdaOe) oeBad++;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R11 reset sdaOe", sdaOe, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset byteValid", byteValid, 0);
    chk("R11 reset commitReq", commitReq, 0);
  endtask

  task automatic testBasicWrite();
    logic a;
    int v0 = validCnt, c0 = commitCnt;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    i2cStart();
    sendByte(8'hA0, a); chk("R1 device address ack", a, 1);
    sendByte(8'hF3, a); chk("R2 address high ack", a, 1);
    sendByte(8'h1E, a); chk("R2 address low ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      sendByte(d[i], a); chk("R3 data ack", a, 1);
    end
    chk("R3 strobe count", validCnt - v0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 data value", logData[(v0 + i) % 16], d[i]);
      chk("R2 R4 address wrap", logAddr[(v0 + i) % 16],
          {7'h18, 5'((5'h1E + i) % 32)});
    end
    i2cStop();
    repeat (4) @(negedge clk);
    chk("R5 commit pulse", commitCnt - c0, 1);
    chk("R5 busy raised", busy, 1);
    waitIdle();
    chk("R5 busy length", busyRun, LIMIT);
    chk("R11 no drive in data bits", oeBad, 0);
  endtask

  task automatic testPolling();
    logic a, firstAck;
    int tries = 0, c0;
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h00, a); sendByte(8'h40, a);
    sendByte(8'h5A, a);
    i2cStop();
    c0 = commitCnt;
    firstAck = 1'b1;
    a = 1'b0;
    while (!a && tries < 40) begin
      i2cStart();
      sendByte(8'hA0, a);
      if (tries == 0) firstAck = a;
      tries++;
      if (!a) i2cStop();
    end
    chk("R6 nack while busy", firstAck, 0);
    chk("R6 ack after busy", a, 1);
    chk("R6 busy low at ack", busy, 0);
    chk("R6 polling needed retries", tries > 1, 1);
    i2cStop();
    repeat (20) @(negedge clk);
    chk("R10 address-only stop no commit", commitCnt - c0, 0);
    chk("R10 no busy", busy, 0);
  endtask

  task automatic testWrongAddr();
    logic a;
    int v0 = validCnt;
    i2cStart();
    sendByte(8'hA2, a); chk("R1 foreign address nack", a, 0);
    sendByte(8'h00, a); chk("R1 later byte ignored", a, 0);
    sendByte(8'h10, a); sendByte(8'h77, a);
    chk("R1 no ack after skip", a, 0);
    i2cStop();
    i2cStart();
    sendByte(8'hA1, a); chk("R1 read direction nack", a, 0);
    i2cStop();
    repeat (10) @(negedge clk);
    chk("R1 no strobe", validCnt - v0, 0);
    chk("R1 no busy", busy, 0);
  endtask

  task automatic testWpReject();
    logic a;
    int v0 = validCnt, c0 = commitCnt;
    wp = 1'b1;
    i2cStart();
    sendByte(8'hA0, a); chk("R7 device ack with wp", a, 1);
    sendByte(8'h02, a); sendByte(8'h20, a); chk("R7 address ack with wp", a, 1);
    sendByte(8'h99, a); chk("R7 first data nack", a, 0);
    sendByte(8'h98, a); chk("R7 second data nack", a, 0);
    i2cStop();
    repeat (10) @(negedge clk);
    wp = 1'b0;
    chk("R7 no strobe", validCnt - v0, 0);
    chk("R7 no commit", commitCnt - c0, 0);
    chk("R7 no busy", busy, 0);
  endtask

  task automatic testWpWindow();
    logic a;
    int v0 = validCnt, c0 = commitCnt;
    wp = 1'b1;
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h05, a);
    wp = 1'b0;
    sendByte(8'h40, a);
    wp = 1'b1;
    sendByte(8'hC1, a); chk("R8 data ack wp late", a, 1);
    sendByte(8'hC2, a); chk("R8 second data ack", a, 1);
    chk("R8 strobes", validCnt - v0, 2);
    chk("R8 address", logAddr[v0 % 16], 12'h540);
    i2cStop();
    repeat (4) @(negedge clk);
    wp = 1'b0;
    chk("R8 commit", commitCnt - c0, 1);
    waitIdle();
  endtask

  task automatic testAbortStop();
    logic a;
    int v0 = validCnt, c0 = commitCnt;
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h00, a); sendByte(8'h08, a);
    sendByte(8'h3C, a);
    chk("R3 byte before abort", validCnt - v0, 1);
    sendBits(8'hF0, 4);
    i2cStop();
    repeat (10) @(negedge clk);
    chk("R9 stop mid-byte no commit", commitCnt - c0, 0);
    chk("R9 stop mid-byte no busy", busy, 0);
  endtask

  task automatic testAbortStart();
    logic a;
    int c0 = commitCnt;
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h00, a); sendByte(8'h09, a);
    sendByte(8'h4D, a);
    sendBits(8'hAA, 3);
    i2cStart();
    sendByte(8'hA0, a); chk("R9 restart device ack", a, 1);
    i2cStop();
    repeat (10) @(negedge clk);
    chk("R9 start mid-byte no commit", commitCnt - c0, 0);
    chk("R9 start mid-byte no busy", busy, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    testBasicWrite();
    testPolling();
    testWrongAddr();
    testWpReject();
    testWpWindow();
    testAbortStop();
    testAbortStart();
    chk("R11 no drive in data bits overall", oeBad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule